// File: doc/BRIEF.md
# Redistributor Sleep Handshake Controller

This block sits between an interrupt redistributor and the CPU interface of one processor core. It holds a 32-bit wake control register. Software sets its sleep bit before powering the core down and clears it after power-up. The block also reports a read-only quiescent bit that software polls to see how the power transition is progressing.

Setting the sleep bit starts two command handshakes toward the CPU interface. One quiesces the link. The other hands back any interrupts already pending there. The quiescent bit rises once both commands have been acknowledged. While the core sleeps, the block does not forward arriving interrupts. It parks them in a bit vector indexed by interrupt ID and raises a wake request for the power controller. After the sleep bit is cleared and the CPU interface reports its link active again, the parked interrupts are delivered lowest ID first, one per cycle.

Access to the register depends on the requester's security state, unless the system runs with a single security state.

Top module: `redist_sleep_ctrl`

## Requirements
- R1: Out of reset the sleep bit and the quiescent bit are both 1. A permitted read of the register returns 0x00000006, no command is raised, and no interrupt is held.
- R2: The register read value carries the sleep bit at bit 1 and the quiescent bit at bit 2. Every other bit reads 0. A write changes only the sleep bit, taking it from write data bit 1.
- R3: The security input encodes 0 as secure, 1 as non-secure, 2 as root and 3 as realm. When the single-security input is 1, every access may read and write the register. When it is 0, non-secure and realm reads return 0 and their writes are ignored.
- R4: The register sits at address 0x14. Reads of any other address return 0, and writes to any other address change nothing.
- R5: A write that takes the sleep bit from 0 to 1 raises both the quiesce command valid and the release command valid from the next cycle. Each one stays high until its own acknowledge is sampled high at a clock edge, and falls at that edge. Rewriting 1 while the sleep bit is already 1 raises nothing.
- R6: The quiescent bit drops to 0 at the 0-to-1 write. It returns to 1 at the clock edge where the last of the two outstanding acknowledges is taken.
- R7: After the sleep bit is cleared, the quiescent bit stays 1 until the link-active input is sampled 1 at a clock edge, and then becomes 0. Clearing the sleep bit while the quiescent bit is 0 is an illegal software sequence and is flagged.
- R8: While the sleep bit or the quiescent bit is 1, no interrupt is forwarded. Every arriving interrupt is held by ID.
- R9: The wake request is high exactly while the sleep bit is 1 and at least one interrupt is held. It falls in the cycle after the write that clears the sleep bit.
- R10: When the link is open (sleep bit and quiescent bit both 0) and nothing is held, an arriving interrupt is forwarded in the same cycle with its own ID.
- R11: When the link is open and interrupts are held, the lowest held ID is forwarded each cycle until the store is empty. Interrupts arriving meanwhile join the store and take their place in ID order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_single_sec | input | 1 | System runs with a single security state |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 32 | Write data |
| bus_sec | input | 2 | Requester security state (0 secure, 1 non-secure, 2 root, 3 realm) |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq_valid | input | 1 | An interrupt arrives this cycle |
| irq_id | input | 5 | ID of the arriving interrupt |
| fwd_valid | output | 1 | Interrupt forwarded to the CPU interface this cycle |
| fwd_id | output | 5 | ID of the forwarded interrupt |
| wake_req | output | 1 | Wake request toward the power controller |
| qsc_valid | output | 1 | Quiesce command valid |
| qsc_ack | input | 1 | Quiesce command acknowledge |
| rel_valid | output | 1 | Release command valid |
| rel_ack | input | 1 | Release command acknowledge |
| link_active | input | 1 | CPU interface reports its link active |

## Verification
The bench targets four corner cases.

- **Acknowledge order.** It returns the two acknowledges in either order and on the same edge. A design that set the quiescent bit on the first acknowledge would report a sleeping core too early.
- **Late link-up.** It clears the sleep bit while the link is still down. A design that reopened forwarding at once would deliver interrupts to a CPU interface that is not ready.
- **Draining with new arrivals.** It lets new interrupts arrive while held ones are being drained, including IDs below the current head. A design with a plain FIFO instead of lowest-first selection would deliver them out of order.
- **Access qualification.** It writes from every security state in both security configurations, to the register and to its neighbour address. A missing qualification would let a non-secure or realm write start a power-down.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    SEC_SECURE = 2'd0,
    SEC_NONSEC = 2'd1,
    SEC_ROOT   = 2'd2,
    SEC_REALM  = 2'd3
  } sec_state_e;

  localparam int REG_W      = 32;
  localparam int SLEEP_POS  = 1;
  localparam int QUIESC_POS = 2;

endpackage

// File: rtl/rsc_regif.sv
module rsc_regif
  import rsc_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_OFFS = 16'h0014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_single_sec,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [1:0]        bus_sec,
  input  logic              quiesc_q,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              sleep_q,
  output logic              wr_sleep_en,
  output logic              wr_sleep_val
);

  logic hit;
  logic access_ok;
  logic sleep_d;

  always_comb begin
    hit       = (bus_addr == REG_OFFS);
    access_ok = cfg_single_sec
              || (sec_state_e'(bus_sec) == SEC_SECURE)
              || (sec_state_e'(bus_sec) == SEC_ROOT);
    wr_sleep_en  = bus_wr && hit && access_ok;
    wr_sleep_val = bus_wdata[SLEEP_POS];
    sleep_d      = wr_sleep_en ? wr_sleep_val : sleep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b1;
    end else if (wr_sleep_en) begin
      sleep_q <= sleep_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit && access_ok) begin
      bus_rdata[SLEEP_POS]  = sleep_q;
      bus_rdata[QUIESC_POS] = quiesc_q;
    end
  end

endmodule

// File: rtl/rsc_handshake.sv
module rsc_handshake #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_q,
  input  logic              wr_sleep_en,
  input  logic              wr_sleep_val,
  input  logic [NUM_CH-1:0] cmd_ack,
  input  logic              link_active,
  output logic [NUM_CH-1:0] cmd_valid,
  output logic              quiesc_q
);

  logic              sleep_rise;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] pend_d;
  logic              quiesc_d;

  assign sleep_rise = wr_sleep_en && wr_sleep_val && !sleep_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      pend_d[c] = sleep_rise ? 1'b1 : (pend_q[c] && !cmd_ack[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[c] <= 1'b0;
      end else if (sleep_rise || pend_q[c]) begin
        pend_q[c] <= pend_d[c];
      end
    end
  end

  assign cmd_valid = pend_q;

  always_comb begin
    quiesc_d = quiesc_q;
    if (sleep_rise) begin
      quiesc_d = 1'b0;
    end else if (sleep_q && (pend_d == '0)) begin
      quiesc_d = 1'b1;
    end else if (!sleep_q && link_active) begin
      quiesc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiesc_q <= 1'b1;
    end else begin
      quiesc_q <= quiesc_d;
    end
  end

endmodule

// File: rtl/rsc_hold_store.sv
module rsc_hold_store #(
  parameter int NUM_IRQ = 32,
  localparam int ID_W   = $clog2(NUM_IRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_q,
  input  logic            link_open,
  input  logic            irq_valid,
  input  logic [ID_W-1:0] irq_id,
  output logic            fwd_valid,
  output logic [ID_W-1:0] fwd_id,
  output logic            wake_req
);

  logic [NUM_IRQ-1:0] held_q;
  logic [NUM_IRQ-1:0] held_d;
  logic [ID_W-1:0]    pick_id;
  logic               any_held;
  logic               direct;
  logic               drain;
  logic               held_en;

  always_comb begin
    pick_id = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (held_q[i]) begin
        pick_id = ID_W'(i);
      end
    end
  end

  always_comb begin
    any_held = |held_q;
    drain    = link_open && any_held;
    direct   = link_open && !any_held && irq_valid;
    held_en  = drain || irq_valid;
    held_d   = held_q;
    if (drain) begin
      held_d[pick_id] = 1'b0;
    end
    if (irq_valid && !direct && (int'(irq_id) < NUM_IRQ)) begin
      held_d[irq_id] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  always_comb begin
    fwd_valid = drain || direct;
    fwd_id    = drain ? pick_id : (direct ? irq_id : '0);
    wake_req  = sleep_q && any_held;
  end

endmodule

// File: rtl/redist_sleep_ctrl.sv
module redist_sleep_ctrl
  import rsc_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 16,
  localparam int ID_W   = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_single_sec,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        bus_sec,
  output logic [31:0]       bus_rdata,
  input  logic              irq_valid,
  input  logic [ID_W-1:0]   irq_id,
  output logic              fwd_valid,
  output logic [ID_W-1:0]   fwd_id,
  output logic              wake_req,
  output logic              qsc_valid,
  input  logic              qsc_ack,
  output logic              rel_valid,
  input  logic              rel_ack,
  input  logic              link_active
);

  logic       sleep_q;
  logic       quiesc_q;
  logic       wr_sleep_en;
  logic       wr_sleep_val;
  logic       link_open;
  logic [1:0] cmd_valid;
  logic [1:0] cmd_ack;

  assign cmd_ack   = {rel_ack, qsc_ack};
  assign qsc_valid = cmd_valid[0];
  assign rel_valid = cmd_valid[1];
  assign link_open = !sleep_q && !quiesc_q;

  rsc_regif #(
    .ADDR_W   (ADDR_W),
    .REG_OFFS (ADDR_W'(16'h0014))
  ) u_regif (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_single_sec (cfg_single_sec),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_sec        (bus_sec),
    .quiesc_q       (quiesc_q),
    .bus_rdata      (bus_rdata),
    .sleep_q        (sleep_q),
    .wr_sleep_en    (wr_sleep_en),
    .wr_sleep_val   (wr_sleep_val)
  );

  rsc_handshake #(
    .NUM_CH (2)
  ) u_hs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_q      (sleep_q),
    .wr_sleep_en  (wr_sleep_en),
    .wr_sleep_val (wr_sleep_val),
    .cmd_ack      (cmd_ack),
    .link_active  (link_active),
    .cmd_valid    (cmd_valid),
    .quiesc_q     (quiesc_q)
  );

  rsc_hold_store #(
    .NUM_IRQ (NUM_IRQ)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_q   (sleep_q),
    .link_open (link_open),
    .irq_valid (irq_valid),
    .irq_id    (irq_id),
    .fwd_valid (fwd_valid),
    .fwd_id    (fwd_id),
    .wake_req  (wake_req)
  );

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker (
  input logic clk,
  input logic rst_n,
  input logic sleep_q,
  input logic quiesc_q,
  input logic wr_sleep_en,
  input logic wr_sleep_val,
  input logic qsc_valid,
  input logic qsc_ack,
  input logic rel_valid,
  input logic rel_ack,
  input logic fwd_valid,
  input logic wake_req
);

  // R5
  qsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qsc_valid && !qsc_ack) |=> qsc_valid);

  // R5
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_ack) |=> rel_valid);

  // R6
  quiesc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiesc_q) |-> (sleep_q && !qsc_valid && !rel_valid));

  // R7
  illegal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sleep_en && !wr_sleep_val && sleep_q) |-> quiesc_q);

  // R8
  no_fwd_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q || quiesc_q) |-> !fwd_valid);

  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> sleep_q);

  // R9
  wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_q) |-> !wake_req);

endmodule

bind redist_sleep_ctrl rsc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_q      (sleep_q),
  .quiesc_q     (quiesc_q),
  .wr_sleep_en  (wr_sleep_en),
  .wr_sleep_val (wr_sleep_val),
  .qsc_valid    (qsc_valid),
  .qsc_ack      (qsc_ack),
  .rel_valid    (rel_valid),
  .rel_ack      (rel_ack),
  .fwd_valid    (fwd_valid),
  .wake_req     (wake_req)
);

// File: tb/redist_sleep_ctrl_tb_top.sv
module redist_sleep_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NIRQ       = 32;
  localparam int IDW        = 5;
  localparam int WDOG_LIMIT = 100000;

  logic           clk;
  logic           rst_n;
  logic           cfg_single_sec;
  logic [15:0]    bus_addr;
  logic           bus_wr;
  logic [31:0]    bus_wdata;
  logic [1:0]     bus_sec;
  logic [31:0]    bus_rdata;
  logic           irq_valid;
  logic [IDW-1:0] irq_id;
  logic           fwd_valid;
  logic [IDW-1:0] fwd_id;
  logic           wake_req;
  logic           qsc_valid;
  logic           qsc_ack;
  logic           rel_valid;
  logic           rel_ack;
  logic           link_active;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  redist_sleep_ctrl dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_single_sec (cfg_single_sec),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_sec        (bus_sec),
    .bus_rdata      (bus_rdata),
    .irq_valid      (irq_valid),
    .irq_id         (irq_id),
    .fwd_valid      (fwd_valid),
    .fwd_id         (fwd_id),
    .wake_req       (wake_req),
    .qsc_valid      (qsc_valid),
    .qsc_ack        (qsc_ack),
    .rel_valid      (rel_valid),
    .rel_ack        (rel_ack),
    .link_active    (link_active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference state
  bit m_sleep;
  bit m_quiesc;
  bit m_qp;
  bit m_rp;
  bit m_held[NIRQ];

  function automatic bit m_allowed();
    return cfg_single_sec || bus_sec == 2'd0 || bus_sec == 2'd2;
  endfunction

  function automatic int m_lowest();
    for (int i = 0; i < NIRQ; i++) if (m_held[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sleep  = 1;
      m_quiesc = 1;
      m_qp     = 0;
      m_rp     = 0;
      foreach (m_held[i]) m_held[i] = 0;
    end else begin
      bit wr, rise, open, nsleep;
      int low;
      wr     = bus_wr && bus_addr == 16'h0014 && m_allowed();
      rise   = wr && bus_wdata[1] && !m_sleep;
      open   = !m_sleep && !m_quiesc;
      low    = m_lowest();
      nsleep = wr ? bus_wdata[1] : m_sleep;
      if (open && low >= 0) m_held[low] = 0;
      if (irq_valid && !(open && low < 0)) m_held[irq_id] = 1;
      m_qp = rise ? 1'b1 : (m_qp && !qsc_ack);
      m_rp = rise ? 1'b1 : (m_rp && !rel_ack);
      if (rise) m_quiesc = 0;
      else if (m_sleep && !m_qp && !m_rp) m_quiesc = 1;
      else if (!m_sleep && link_active) m_quiesc = 0;
      m_sleep = nsleep;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare();
    longint exp_rd;
    string  rtag;
    bit     open;
    int     low;
    exp_rd = 0;
    if (bus_addr != 16'h0014) rtag = "R4";
    else if (!m_allowed()) rtag = "R3";
    else begin
      rtag   = "R2";
      exp_rd = (longint'(m_quiesc) << 2) | (longint'(m_sleep) << 1);
    end
    chk(rtag, bus_rdata, exp_rd);
    chk("R5", qsc_valid, m_qp);
    chk("R5", rel_valid, m_rp);
    low  = m_lowest();
    chk("R9", wake_req, m_sleep && low >= 0);
    open = !m_sleep && !m_quiesc;
    if (!open) chk("R8", fwd_valid, 0);
    else if (low >= 0) begin
      chk("R11", fwd_valid, 1);
      chk("R11", fwd_id, low);
    end else begin
      chk("R10", fwd_valid, irq_valid);
      if (irq_valid) chk("R10", fwd_id, irq_id);
    end
  endtask

  task automatic tick();
    #1 compare();
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
    irq_valid = 1'b0;
    irq_id    = '0;
    qsc_ack   = 1'b0;
    rel_ack   = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] sec, logic [15:0] addr, logic [31:0] data);
    bus_sec   = sec;
    bus_addr  = addr;
    bus_wr    = 1'b1;
    bus_wdata = data;
    tick();
    bus_addr  = 16'h0014;
    bus_sec   = 2'd0;
  endtask

  task automatic irq_in(int id);
    irq_valid = 1'b1;
    irq_id    = IDW'(id);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG_LIMIT) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=below %0d", cyc, WDOG_LIMIT);
      summary();
    end
  end

  initial begin
    rst_n          = 1'b0;
    cfg_single_sec = 1'b0;
    bus_addr       = 16'h0014;
    bus_wr         = 1'b0;
    bus_wdata      = '0;
    bus_sec        = 2'd0;
    irq_valid      = 1'b0;
    irq_id         = '0;
    qsc_ack        = 1'b0;
    rel_ack        = 1'b0;
    link_active    = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 chk("R1", bus_rdata, 32'h6);
    chk("R1", qsc_valid, 0);
    chk("R1", wake_req, 0);
    bus_sec = 2'd1;
    #1 chk("R3", bus_rdata, 0);
    bus_sec = 2'd0;
    tick();

    // R8 / R9 hold while asleep
    irq_in(7); tick();
    irq_in(3); tick();
    #1 chk("R9", wake_req, 1);
    chk("R8", fwd_valid, 0);

    // R7 clear sleep (legal, quiescent is 1), link active
    wr_reg(2'd0, 16'h0014, 32'h0);
    #1 chk("R7", bus_rdata, 32'h4);
    chk("R9", wake_req, 0);
    chk("R8", fwd_valid, 0);
    tick();
    #1 chk("R7", bus_rdata, 32'h0);
    chk("R11", fwd_id, 3);
    irq_in(1); tick();
    #1 chk("R11", fwd_id, 1);
    tick();
    #1 chk("R11", fwd_id, 7);
    tick();
    #1 chk("R11", fwd_valid, 0);
    irq_in(9);
    #1 chk("R10", fwd_id, 9);
    chk("R10", fwd_valid, 1);
    tick();

    // R3 non-secure and realm writes ignored
    wr_reg(2'd1, 16'h0014, 32'h2);
    wr_reg(2'd3, 16'h0014, 32'h2);
    #1 chk("R3", bus_rdata, 0);
    chk("R3", qsc_valid, 0);
    // R4 other address
    wr_reg(2'd0, 16'h0018, 32'h2);
    #1 chk("R4", bus_rdata, 0);
    bus_addr = 16'h0018;
    #1 chk("R4", bus_rdata, 0);
    bus_addr = 16'h0014;
    tick();

    // R5 / R6 root write with all bits set
    wr_reg(2'd2, 16'h0014, 32'hFFFF_FFFF);
    #1 chk("R2", bus_rdata, 32'h2);
    chk("R5", qsc_valid, 1);
    chk("R5", rel_valid, 1);
    tick(); tick();
    rel_ack = 1'b1; tick();
    #1 chk("R6", rel_valid, 0);
    chk("R6", qsc_valid, 1);
    chk("R6", bus_rdata, 32'h2);
    qsc_ack = 1'b1; tick();
    #1 chk("R6", bus_rdata, 32'h6);
    wr_reg(2'd0, 16'h0014, 32'h2);
    #1 chk("R5", qsc_valid, 0);

    // R7 link comes up late
    link_active = 1'b0;
    wr_reg(2'd0, 16'h0014, 32'h0);
    tick(); tick();
    #1 chk("R7", bus_rdata, 32'h4);
    irq_in(5);
    #1 chk("R8", fwd_valid, 0);
    tick();
    link_active = 1'b1;
    tick();
    #1 chk("R7", bus_rdata, 32'h0);
    chk("R11", fwd_id, 5);
    tick();

    // R3 single security state: non-secure may write
    cfg_single_sec = 1'b1;
    wr_reg(2'd1, 16'h0014, 32'h2);
    bus_sec = 2'd1;
    #1 chk("R3", bus_rdata, 32'h2);
    qsc_ack = 1'b1; rel_ack = 1'b1; tick();
    #1 chk("R6", bus_rdata, 32'h6);
    bus_sec = 2'd0;
    cfg_single_sec = 1'b0;

    // Random phase against the reference model
    for (int n = 0; n < 4000; n++) begin
      cfg_single_sec = ($urandom_range(0, 7) == 0);
      bus_sec        = 2'($urandom_range(0, 3));
      bus_addr       = ($urandom_range(0, 5) == 0) ? 16'h0018 : 16'h0014;
      link_active    = ($urandom_range(0, 3) != 0);
      qsc_ack        = ($urandom_range(0, 2) == 0);
      rel_ack        = ($urandom_range(0, 2) == 0);
      irq_valid      = ($urandom_range(0, 2) == 0);
      irq_id         = IDW'($urandom_range(0, NIRQ - 1));
      bus_wr         = ($urandom_range(0, 9) == 0);
      bus_wdata      = $urandom;
      // R7: never clear sleep while quiescent is 0
      if (bus_wr && !bus_wdata[1] && m_sleep && !m_quiesc) bus_wdata[1] = 1'b1;
      tick();
    end

    summary();
  end

endmodule